// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue FIFO Manager

This block keeps many independent circular word queues inside a single on-chip SRAM. Each queue is set up by one 32-bit configuration word. The word gives the queue's start page in the SRAM, its length and two watermark codes. After that, a host pushes words into a queue and pops words out of it through one request stream, with each request naming the queue it targets. Every queue keeps its own read pointer, write pointer and occupancy count in flops. The SRAM holds only the payload words.

Status is exported continuously for a separate interrupt block to use. The lower half of the queues report a 4-bit flag nibble each and a 2-bit auxiliary field that holds a sticky overflow flag. The upper half report only two flags each, packed into two bit vectors: nearly empty and full. Placing queues in the SRAM is a software matter. Queues whose page ranges overlap really do share SRAM words.

The request stream is valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops during any cycle in which a configuration write is presented. It also drops while a read response is waiting and `rsp_ready` is low, so back-pressure on the response channel stalls the request channel. A read request gives exactly one response beat, and `rsp_valid` rises in the cycle after the request transfers. Write requests produce no response.

Top module: `qmgr_fifo_mgr`

## Requirements
- R1: After reset, every low-half nibble reads 0x3, the whole auxiliary vector reads 0, the high nearly-empty vector reads all ones and the high full vector reads 0.
- R2: In a configuration word, bits 25:24 select the length: code 0 gives 16 words, 1 gives 32, 2 gives 64 and 3 gives 128. Bits 21:14 give the start page, where a page is 16 words and the page index wraps modulo 128. Writing any configuration word to a queue empties it and clears its overflow flag. A word of zero also disables the queue: pushes to a disabled queue are dropped, and pops from it return 0. Queues with overlapping page ranges share the same SRAM words.
- R3: Each queue returns the words pushed into it in first-in, first-out order. A push request has `req_write`=1 and a pop request has `req_write`=0.
- R4: A pop from an empty queue returns the value 0 and leaves the queue's state unchanged.
- R5: A push to a full queue is dropped. For a low-half queue the push also sets that queue's overflow flag. The flag stays set until that queue is configured again. High-half queues have no overflow flag.
- R6: Low queue q has its nibble at `lo_status[4q+3:4q]`. This is the same as word q/8, offset (q mod 8)·4. Within the nibble, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R7: A watermark code n stands for a level T(n). T(0) is 0, and for any other n, T(n) is 2^(n−1). A queue is nearly empty when its count is at most T(bits 28:26). It is nearly full when its free slots number at most T(bits 31:29).
- R8: Low queue q has a 2-bit auxiliary field at `lo_aux[2q+1:2q]`. Bit 0 is the overflow flag and bit 1 always reads 0.
- R9: For a high queue q, bit q−32 of `hi_nearly_empty` is its nearly-empty flag and bit q−32 of `hi_full` is its full flag.
- R10: `req_ready` is low whenever `cfg_we` is high, and also whenever a response is held with `rsp_ready` low. `rsp_valid` rises in the cycle after a pop transfers. `rsp_data` stays stable until the beat is taken.
- R11: Each queue's read and write pointers wrap modulo its configured length, so a queue can be filled and drained again and again past its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | 6 | Queue being configured |
| cfg_data | input | 32 | Configuration word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = push, 0 = pop |
| req_queue | input | 6 | Target queue of the request |
| req_data | input | 32 | Word to push |
| rsp_valid | output | 1 | Pop response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Popped word, or 0 |
| lo_status | output | 128 | Flag nibbles of queues 0–31 |
| lo_aux | output | 64 | Auxiliary fields of queues 0–31 |
| hi_nearly_empty | output | 32 | Nearly-empty flags of queues 32–63 |
| hi_full | output | 32 | Full flags of queues 32–63 |

## Verification
The hardest situation to reach is two queues aliasing the same SRAM words, because it only shows up when software deliberately overlaps their page ranges. The bench sets this up with two queues on the same start page and checks that a pop from the first returns the word pushed into the second. Overflow on a low queue, and its absence on a high queue, needs each queue filled exactly to its length plus one. Back-pressure is reached by randomly dropping `rsp_ready` during mixed push/pop traffic over queues of all four lengths. A behavioural model is compared against the outputs on every cycle.

// File: rtl/qmgr_pkg.sv
package qmgr_pkg;
  localparam int CFG_W = 32;
  localparam int PTR_W = 7;   // longest queue is 128 words
  localparam int CNT_W = 8;   // occupancy 0..128

  typedef struct packed {
    logic [2:0] nf_code;
    logic [2:0] ne_code;
    logic [1:0] len_code;
    logic [1:0] spare;
    logic [7:0] base_page;
    logic [13:0] low_bits;
  } qcfg_t;

  function automatic logic [CNT_W-1:0] qlen_words(input logic [1:0] code);
    return CNT_W'(16) << code;
  endfunction

  function automatic logic [CNT_W-1:0] wm_level(input logic [2:0] code);
    return (code == 3'd0) ? '0 : (CNT_W'(1) << (code - 3'd1));
  endfunction
endpackage

// File: rtl/qmgr_sram.sv
module qmgr_sram #(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/qmgr_qtable.sv
module qmgr_qtable
  import qmgr_pkg::*;
#(
  parameter int NQ  = 64,
  parameter int QW  = 6,
  parameter int PGW = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [QW-1:0]                 cfg_sel,
  input  logic [CFG_W-1:0]              cfg_word,
  input  logic [QW-1:0]                 op_sel,
  input  logic                          push,
  input  logic                          pop,
  input  logic                          ovf_set,
  output logic [NQ-1:0]                 en_o,
  output logic [NQ-1:0][1:0]            lenc_o,
  output logic [NQ-1:0][2:0]            nec_o,
  output logic [NQ-1:0][2:0]            nfc_o,
  output logic [NQ-1:0][PGW-1:0]        base_o,
  output logic [NQ-1:0][PTR_W-1:0]      rp_o,
  output logic [NQ-1:0][PTR_W-1:0]      wp_o,
  output logic [NQ-1:0][CNT_W-1:0]      cnt_o,
  output logic [NQ-1:0]                 ovf_o
);
  qcfg_t wcfg;
  assign wcfg = qcfg_t'(cfg_word);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wcfg.spare, wcfg.low_bits, wcfg.base_page[7:PGW]};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic             en_r, ovf_r;
    logic [1:0]       lenc_r;
    logic [2:0]       nec_r, nfc_r;
    logic [PGW-1:0]   base_r;
    logic [PTR_W-1:0] rp_r, wp_r, wrap_mask;
    logic [CNT_W-1:0] cnt_r;
    logic             hit_cfg, hit_op;

    assign hit_cfg   = cfg_we && (cfg_sel == QW'(q));
    assign hit_op    = (op_sel == QW'(q));
    assign wrap_mask = PTR_W'(qlen_words(lenc_r) - CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        lenc_r <= '0;
        nec_r  <= '0;
        nfc_r  <= '0;
        base_r <= '0;
        rp_r   <= '0;
        wp_r   <= '0;
        cnt_r  <= '0;
        ovf_r  <= 1'b0;
      end else if (hit_cfg) begin
        en_r   <= |cfg_word;
        lenc_r <= wcfg.len_code;
        nec_r  <= wcfg.ne_code;
        nfc_r  <= wcfg.nf_code;
        base_r <= wcfg.base_page[PGW-1:0];
        rp_r   <= '0;
        wp_r   <= '0;
        cnt_r  <= '0;
        ovf_r  <= 1'b0;
      end else if (hit_op) begin
        if (push) begin
          wp_r  <= (wp_r + PTR_W'(1)) & wrap_mask;
          cnt_r <= cnt_r + CNT_W'(1);
        end
        if (pop) begin
          rp_r  <= (rp_r + PTR_W'(1)) & wrap_mask;
          cnt_r <= cnt_r - CNT_W'(1);
        end
        if (ovf_set) ovf_r <= 1'b1;
      end
    end

    assign en_o[q]   = en_r;
    assign lenc_o[q] = lenc_r;
    assign nec_o[q]  = nec_r;
    assign nfc_o[q]  = nfc_r;
    assign base_o[q] = base_r;
    assign rp_o[q]   = rp_r;
    assign wp_o[q]   = wp_r;
    assign cnt_o[q]  = cnt_r;
    assign ovf_o[q]  = ovf_r;
  end
endmodule

// File: rtl/qmgr_status_pack.sv
module qmgr_status_pack
  import qmgr_pkg::*;
#(
  parameter int NQ = 64
) (
  input  logic [NQ-1:0][1:0]       lenc_i,
  input  logic [NQ-1:0][2:0]       nec_i,
  input  logic [NQ-1:0][2:0]       nfc_i,
  input  logic [NQ-1:0][CNT_W-1:0] cnt_i,
  input  logic [NQ-1:0]            ovf_i,
  output logic [(NQ/2)*4-1:0]      lo_stat_o,
  output logic [(NQ/2)*2-1:0]      lo_aux_o,
  output logic [NQ/2-1:0]          hi_ne_o,
  output logic [NQ/2-1:0]          hi_full_o
);
  localparam int LO_Q = NQ / 2;

  for (genvar q = 0; q < NQ; q++) begin : g_st
    logic [CNT_W-1:0] cap;
    logic             f_empty, f_nempty, f_nfull, f_full;

    assign cap      = qlen_words(lenc_i[q]);
    assign f_empty  = (cnt_i[q] == '0);
    assign f_full   = (cnt_i[q] == cap);
    assign f_nempty = (cnt_i[q] <= wm_level(nec_i[q]));
    assign f_nfull  = ((cap - cnt_i[q]) <= wm_level(nfc_i[q]));

    if (q < LO_Q) begin : g_lo
      assign lo_stat_o[4*q +: 4] = {f_full, f_nfull, f_nempty, f_empty};
      assign lo_aux_o[2*q +: 2]  = {1'b0, ovf_i[q]};
    end else begin : g_hi
      logic unused_hi_flags;
      assign unused_hi_flags      = ^{f_empty, f_nfull, ovf_i[q]};
      assign hi_ne_o[q - LO_Q]    = f_nempty;
      assign hi_full_o[q - LO_Q]  = f_full;
    end
  end
endmodule

// File: rtl/qmgr_fifo_mgr.sv
module qmgr_fifo_mgr
  import qmgr_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_Q)-1:0]   cfg_queue,
  input  logic [31:0]                cfg_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [$clog2(NUM_Q)-1:0]   req_queue,
  input  logic [DATA_W-1:0]          req_data,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [(NUM_Q/2)*4-1:0]     lo_status,
  output logic [(NUM_Q/2)*2-1:0]     lo_aux,
  output logic [NUM_Q/2-1:0]         hi_nearly_empty,
  output logic [NUM_Q/2-1:0]         hi_full
);
  localparam int QW    = $clog2(NUM_Q);
  localparam int LO_Q  = NUM_Q / 2;
  localparam int OFS_W = $clog2(PAGE_WORDS);
  localparam int PGW   = $clog2(NUM_PAGES);
  localparam int AW    = OFS_W + PGW;

  logic [NUM_Q-1:0]            en_all, ovf_all;
  logic [NUM_Q-1:0][1:0]       lenc_all;
  logic [NUM_Q-1:0][2:0]       nec_all, nfc_all;
  logic [NUM_Q-1:0][PGW-1:0]   base_all;
  logic [NUM_Q-1:0][PTR_W-1:0] rp_all, wp_all;
  logic [NUM_Q-1:0][CNT_W-1:0] cnt_all;

  logic             accept, rd_go, do_push, do_pop, do_ovf;
  logic             sel_en, sel_full, sel_empty, sel_low;
  logic [CNT_W-1:0] sel_cap, sel_cnt;
  logic [AW-1:0]    page_addr, wr_addr, rd_addr;
  logic [DATA_W-1:0] sram_q;
  logic             rsp_blank;

  // request channel
  assign req_ready = !cfg_we && !(rsp_valid && !rsp_ready);
  assign accept    = req_valid && req_ready;
  assign rd_go     = accept && !req_write;

  assign sel_en    = en_all[req_queue];
  assign sel_cnt   = cnt_all[req_queue];
  assign sel_cap   = qlen_words(lenc_all[req_queue]);
  assign sel_full  = (sel_cnt == sel_cap);
  assign sel_empty = (sel_cnt == '0);
  assign sel_low   = (req_queue < QW'(LO_Q));

  assign do_push = accept && req_write && sel_en && !sel_full;
  assign do_ovf  = accept && req_write && sel_en && sel_full && sel_low;
  assign do_pop  = rd_go && sel_en && !sel_empty;

  assign page_addr = {base_all[req_queue], OFS_W'(0)};
  assign wr_addr   = page_addr + AW'(wp_all[req_queue]);
  assign rd_addr   = page_addr + AW'(rp_all[req_queue]);

  qmgr_qtable #(
    .NQ (NUM_Q),
    .QW (QW),
    .PGW(PGW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_queue),
    .cfg_word(cfg_data),
    .op_sel  (req_queue),
    .push    (do_push),
    .pop     (do_pop),
    .ovf_set (do_ovf),
    .en_o    (en_all),
    .lenc_o  (lenc_all),
    .nec_o   (nec_all),
    .nfc_o   (nfc_all),
    .base_o  (base_all),
    .rp_o    (rp_all),
    .wp_o    (wp_all),
    .cnt_o   (cnt_all),
    .ovf_o   (ovf_all)
  );

  qmgr_sram #(
    .DW(DATA_W),
    .AW(AW)
  ) u_sram (
    .clk    (clk),
    .wr_en  (do_push),
    .wr_addr(wr_addr),
    .wr_data(req_data),
    .rd_en  (do_pop),
    .rd_addr(rd_addr),
    .rd_data(sram_q)
  );

  qmgr_status_pack #(
    .NQ(NUM_Q)
  ) u_status (
    .lenc_i   (lenc_all),
    .nec_i    (nec_all),
    .nfc_i    (nfc_all),
    .cnt_i    (cnt_all),
    .ovf_i    (ovf_all),
    .lo_stat_o(lo_status),
    .lo_aux_o (lo_aux),
    .hi_ne_o  (hi_nearly_empty),
    .hi_full_o(hi_full)
  );

  // response register: one beat per accepted pop request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_blank <= 1'b1;
    end else if (rd_go) begin
      rsp_valid <= 1'b1;
      rsp_blank <= !do_pop;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_data = rsp_blank ? '0 : sram_q;
endmodule

// File: rtl/qmgr_fifo_mgr_chk.sv
module qmgr_fifo_mgr_chk #(
  parameter int NUM_Q  = 64,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [$clog2(NUM_Q)-1:0] cfg_queue,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [$clog2(NUM_Q)-1:0] req_queue,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [DATA_W-1:0]        rsp_data,
  input logic [(NUM_Q/2)*4-1:0]   lo_status,
  input logic [(NUM_Q/2)*2-1:0]   lo_aux,
  input logic [NUM_Q/2-1:0]       hi_full
);
  localparam int QW   = $clog2(NUM_Q);
  localparam int LO_Q = NUM_Q / 2;

  AST_CFG_STALLS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_ready);  // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));  // R10

  AST_POP_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);  // R10

  for (genvar i = 0; i < LO_Q; i++) begin : g_lo_chk
    AST_EMPTY_IS_NEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      lo_status[4*i] |-> lo_status[4*i+1]);  // R7

    AST_FULL_IS_NEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      lo_status[4*i+3] |-> lo_status[4*i+2]);  // R7

    AST_OVF_CLEARS_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lo_aux[2*i]) |-> $past(cfg_we && (cfg_queue == QW'(i))));  // R5

    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_aux[2*i]) |-> $past(lo_status[4*i+3]));  // R5
  end

  for (genvar j = 0; j < LO_Q; j++) begin : g_hi_chk
    AST_HI_FULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_full[j]) |-> $past(req_valid && req_ready && req_write &&
                                  (req_queue == QW'(j + LO_Q))));  // R9
  end
endmodule

bind qmgr_fifo_mgr qmgr_fifo_mgr_chk #(
  .NUM_Q (NUM_Q),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/qmgr_fifo_mgr_tb_top.sv
module qmgr_fifo_mgr_tb_top;
  localparam int NQ  = 64;
  localparam int LO  = 32;
  localparam int MEMW = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_queue = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_queue = '0;
  logic [31:0] req_data = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [127:0] lo_status;
  logic [63:0]  lo_aux;
  logic [31:0]  hi_nearly_empty, hi_full;
  bit           bp_en = 1'b0;

  qmgr_fifo_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_queue(cfg_queue),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_queue(req_queue), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .lo_status(lo_status), .lo_aux(lo_aux),
    .hi_nearly_empty(hi_nearly_empty), .hi_full(hi_full)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cfg [NQ];
  int          m_rp [NQ];
  int          m_wp [NQ];
  int          m_cnt [NQ];
  bit          m_ovf [NQ];
  logic [31:0] m_mem [MEMW];
  bit          m_rv;
  logic [31:0] m_rd;
  wire         m_ready = !cfg_we && !(m_rv && !rsp_ready);

  function automatic int qlen(input logic [31:0] c);
    return 16 << c[25:24];
  endfunction
  function automatic int thr(input logic [2:0] n);
    return (n == 3'd0) ? 0 : (1 << (int'(n) - 1));
  endfunction
  function automatic int maddr(input logic [31:0] c, input int p);
    return (int'(c[20:14]) * 16 + p) % MEMW;
  endfunction
  function automatic logic [3:0] exp_nib(input int q);
    int ln = qlen(m_cfg[q]);
    int c = m_cnt[q];
    logic [3:0] r;
    r[0] = (c == 0);
    r[1] = (c <= thr(m_cfg[q][28:26]));
    r[2] = ((ln - c) <= thr(m_cfg[q][31:29]));
    r[3] = (c == ln);
    return r;
  endfunction

  always @(posedge clk) begin
    int q;
    int ln;
    bit rdy;
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        m_cfg[i] = '0; m_rp[i] = 0; m_wp[i] = 0; m_cnt[i] = 0; m_ovf[i] = 1'b0;
      end
      m_rv = 1'b0;
      m_rd = '0;
    end else begin
      rdy = m_ready;
      if (m_rv && rsp_ready) m_rv = 1'b0;
      if (cfg_we) begin
        q = int'(cfg_queue);
        m_cfg[q] = cfg_data; m_rp[q] = 0; m_wp[q] = 0; m_cnt[q] = 0; m_ovf[q] = 1'b0;
      end else if (req_valid && rdy) begin
        q = int'(req_queue);
        ln = qlen(m_cfg[q]);
        if (req_write) begin
          if (m_cfg[q] != '0) begin
            if (m_cnt[q] < ln) begin
              m_mem[maddr(m_cfg[q], m_wp[q])] = req_data;
              m_wp[q] = (m_wp[q] + 1) % ln;
              m_cnt[q]++;
            end else if (q < LO) begin
              m_ovf[q] = 1'b1;
            end
          end
        end else begin
          m_rv = 1'b1;
          if (m_cfg[q] != '0 && m_cnt[q] > 0) begin
            m_rd = m_mem[maddr(m_cfg[q], m_rp[q])];
            m_rp[q] = (m_rp[q] + 1) % ln;
            m_cnt[q]--;
          end else begin
            m_rd = '0;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [127:0] e_lo;
    logic [63:0]  e_aux;
    logic [31:0]  e_hne, e_hf;
    #3;
    if (rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        logic [3:0] n;
        n = exp_nib(q);
        if (q < LO) begin
          e_lo[4*q +: 4] = n;
          e_aux[2*q +: 2] = {1'b0, m_ovf[q]};
        end else begin
          e_hne[q-LO] = n[1];
          e_hf[q-LO] = n[3];
        end
      end
      chk(req_ready === m_ready, "R10 req_ready", 128'(req_ready), 128'(m_ready));
      chk(rsp_valid === m_rv, "R10 rsp_valid", 128'(rsp_valid), 128'(m_rv));
      if (m_rv) chk(rsp_data === m_rd, "R3 rsp_data", 128'(rsp_data), 128'(m_rd));
      chk(lo_status === e_lo, "R6 R7 lo_status", lo_status, e_lo);
      chk(lo_aux === e_aux, "R8 lo_aux", 128'(lo_aux), 128'(e_aux));
      chk(hi_nearly_empty === e_hne, "R9 R7 hi_nearly_empty", 128'(hi_nearly_empty), 128'(e_hne));
      chk(hi_full === e_hf, "R9 hi_full", 128'(hi_full), 128'(e_hf));
    end
  end

  always @(negedge clk) rsp_ready <= bp_en ? ($urandom % 3 != 0) : 1'b1;

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input int q, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_queue = 6'(q); cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic push(input int q, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_queue = 6'(q); req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pull(input int q, output logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_queue = 6'(q);
    #1;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (rsp_valid && rsp_ready) break;
    end
    d = rsp_data;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] mkcfg(input int nf, input int ne, input int lc, input int pg);
    return (32'(nf) << 29) | (32'(ne) << 26) | (32'(lc) << 24) | (32'(pg) << 14);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int qs[5] = '{3, 40, 7, 60, 12};
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #3;
    chk(lo_status === {32{4'h3}}, "R1 lo_status reset", lo_status, {32{4'h3}});
    chk(lo_aux === '0, "R1 lo_aux reset", 128'(lo_aux), 128'(0));
    chk(hi_nearly_empty === '1, "R1 hi_nearly_empty reset", 128'(hi_nearly_empty), 128'(32'hFFFF_FFFF));
    chk(hi_full === '0, "R1 hi_full reset", 128'(hi_full), 128'(0));

    // low queue fill past full, overflow, drain, empty read
    cfg_write(3, mkcfg(3, 2, 0, 4));
    for (int i = 0; i < 17; i++) push(3, 32'h100 + 32'(i));
    chk(lo_aux[6] === 1'b1, "R5 overflow set", 128'(lo_aux[6]), 128'(1));
    chk(lo_status[15:12] === 4'b1100, "R6 full nibble", 128'(lo_status[15:12]), 128'(4'b1100));
    for (int i = 0; i < 16; i++) begin
      pull(3, d);
      chk(d === 32'h100 + 32'(i), "R3 fifo order", 128'(d), 128'(32'h100 + 32'(i)));
    end
    pull(3, d);
    chk(d === '0, "R4 empty read", 128'(d), 128'(0));
    chk(lo_status[15:12] === 4'b0011, "R4 state unchanged", 128'(lo_status[15:12]), 128'(4'b0011));
    chk(lo_aux[6] === 1'b1, "R5 overflow sticky", 128'(lo_aux[6]), 128'(1));
    cfg_write(3, mkcfg(3, 2, 0, 4));
    chk(lo_aux[6] === 1'b0, "R5 overflow cleared by config", 128'(lo_aux[6]), 128'(0));

    // high queue, length 32
    cfg_write(40, mkcfg(0, 1, 1, 8));
    for (int i = 0; i < 33; i++) push(40, 32'h4000 + 32'(i));
    chk(hi_full[8] === 1'b1, "R9 high full", 128'(hi_full[8]), 128'(1));
    chk(lo_aux === '0, "R5 no overflow flag for high queue", 128'(lo_aux), 128'(0));
    for (int i = 0; i < 32; i++) begin
      pull(40, d);
      chk(d === 32'h4000 + 32'(i), "R2 R3 length 32 order", 128'(d), 128'(32'h4000 + 32'(i)));
    end

    // pointer wrap
    cfg_write(7, mkcfg(1, 1, 0, 20));
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 11; i++) push(7, 32'(r * 100 + i));
      for (int i = 0; i < 11; i++) begin
        pull(7, d);
        chk(d === 32'(r * 100 + i), "R11 wrap order", 128'(d), 128'(32'(r * 100 + i)));
      end
    end

    // aliasing through overlapping pages
    cfg_write(5, mkcfg(0, 0, 0, 30));
    cfg_write(45, mkcfg(0, 0, 0, 30));
    push(5, 32'hAAAA_0001);
    push(45, 32'hBBBB_0002);
    pull(5, d);
    chk(d === 32'hBBBB_0002, "R2 shared page alias", 128'(d), 128'(32'hBBBB_0002));
    pull(45, d);

    // disabled queue
    push(9, 32'hDEAD_0009);
    pull(9, d);
    chk(d === '0, "R2 disabled queue read", 128'(d), 128'(0));
    chk(lo_status[39:36] === 4'h3, "R2 disabled queue status", 128'(lo_status[39:36]), 128'(4'h3));

    // reconfigure discards contents
    for (int i = 0; i < 3; i++) push(7, 32'h77);
    cfg_write(7, mkcfg(1, 1, 0, 20));
    pull(7, d);
    chk(d === '0, "R2 reconfig empties queue", 128'(d), 128'(0));

    // random mixed traffic with response back-pressure
    cfg_write(60, mkcfg(5, 7, 2, 40));
    cfg_write(12, mkcfg(7, 4, 3, 60));
    bp_en = 1'b1;
    for (int k = 0; k < 2500; k++) begin
      int q = qs[$urandom % 5];
      if ($urandom % 10 < 6) push(q, $urandom);
      else pull(q, d);
      if (k % 400 == 0) cfg_write(3, mkcfg(3, 2, 0, 4));
    end
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule